// File: doc/BRIEF.md
# Bus Error Capture and Threshold

This block sits beside a processor system bus and records why a machine check or a transfer error was raised. Each cycle it receives strobes for the possible causes: a correctable (single-bit) ECC error, an uncorrectable (double-bit) ECC error, a parity error, the external machine-check pin, a watchdog timeout and an address-only bus-monitor timeout. It also receives the transfer code and transfer type of the transaction in flight. From these it drives a registered machine-check request and a registered transfer-error indication.

Correctable errors do not escalate at once. An 8-bit counter absorbs them and saturates at its maximum. Once it is full, every further correctable error raises a machine check. Software can preload the counter to shorten the tolerance. Sticky per-cause flags and a frozen snapshot of the first faulting transaction's code and type let software find out afterwards what happened.

Software access is through a small word-wide register port. Address 0 holds status and control, address 1 holds the counter, and any other address reads as zero. Reads are combinational. Writes take effect at the clock edge.

Top module: `bus_err_capture`

## Requirements
- R1: Each enabled single-bit error adds one to the 8-bit counter (address 1, bits [7:0]). At 255 the counter stays at 255.
- R2: A single-bit error that arrives while the counter reads 255 drives mcp_o high in the next cycle. One that arrives below 255 leaves mcp_o and tea_o low.
- R3: Writing address 1 loads bits [7:0] into the counter. Later errors count up from the loaded value.
- R4: Control bit 8 at address 0 disables data errors when it is 1. While it is 1, single-bit, double-bit and parity errors raise no machine check and no transfer error, leave the counter unchanged and set no flag. The bit resets to 0, which means data errors are enabled.
- R5: An enabled double-bit or parity error drives both mcp_o and tea_o high in the next cycle and leaves the counter unchanged.
- R6: Sticky bit 9 at address 0 is set whenever a data error causes a machine check. This covers double-bit errors, parity errors and saturated single-bit errors.
- R7: Sticky bits 10, 11 and 12 at address 0 are set by the external pin, the watchdog timeout and the address-only timeout respectively. Each of these causes drives mcp_o high in the next cycle but not tea_o.
- R8: On a machine check, the transfer code is captured into bits [2:0] and the transfer type into bits [7:3], but only while no sticky flag is set. While any flag is set, both fields are frozen. Writing 1 to a flag bit clears that flag alone. The fields keep their values until the next capture.
- R9: If a counter write and a single-bit error fall in the same cycle, the counter takes the written value.
- R10: Reset clears the counter, the flags, the captured fields, the disable bit and both outputs. Reserved bits read 0 and ignore writes. The captured fields ignore writes. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sbe_i | input | 1 | Single-bit ECC error strobe |
| dbe_i | input | 1 | Double-bit ECC error strobe |
| par_i | input | 1 | Parity error strobe |
| ext_mc_i | input | 1 | External machine-check pin |
| wdog_i | input | 1 | Watchdog timeout strobe |
| ao_to_i | input | 1 | Address-only bus-monitor timeout strobe |
| xfer_code_i | input | 3 | Transfer code of the current transaction |
| xfer_type_i | input | 5 | Transfer type of the current transaction |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mcp_o | output | 1 | Machine-check request |
| tea_o | output | 1 | Transfer-error indication |

## Verification
The hardest state to reach is the boundary of the counter: the step from 254 to 255 without escalation, followed by the first escalating error at 255. From reset, getting there takes 255 correctable errors.

The bench reaches this boundary two ways. First, it sweeps every counter value from 0 up through saturation, one strobe at a time, and predicts arithmetically the count and mcp_o for each step. Second, it preloads the counter near the top so the same edge is crossed from a software-set value. The collision of a counter write with an error in the same cycle is driven deliberately on a single cycle.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_COUNT  = 1;
  localparam int unsigned DIS_BIT    = 8;
  localparam int unsigned FLAG_LSB   = 9;
  localparam int unsigned NUM_FLAGS  = 4;

  typedef enum logic [1:0] {
    FLG_DATA = 2'd0,
    FLG_EXT  = 2'd1,
    FLG_WDOG = 2'd2,
    FLG_AO   = 2'd3
  } flag_idx_e;
endpackage

// File: rtl/bec_ecc_counter.sv
module bec_ecc_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sbe_i,
  input  logic             dis_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (load_i)                            cnt_q <= load_val_i;  // software wins
    else if (sbe_i && !dis_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign sat_o = (cnt_q == CNT_MAX);

  assert_sat_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) && !load_i |=> cnt_q == CNT_MAX);
  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_dis_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i && !load_i |=> $stable(cnt_q));
endmodule

// File: rtl/bec_capture.sv
module bec_capture
  import bec_pkg::*;
#(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned TYPE_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mc_i,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic [TYPE_W-1:0]    type_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [CODE_W-1:0]    code_o,
  output logic [TYPE_W-1:0]    type_o
);
  logic [NUM_FLAGS-1:0] flags_q;
  logic [CODE_W-1:0]    code_q;
  logic [TYPE_W-1:0]    type_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flags_q[g] <= 1'b0;
      else if (set_i[g])                  flags_q[g] <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_mask_i[g]) flags_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      type_q <= '0;
    end else if (mc_i && flags_q == '0) begin
      code_q <= code_i;
      type_q <= type_i;
    end
  end

  assign flags_o = flags_q;
  assign code_o  = code_q;
  assign type_o  = type_q;

  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q != '0) |=> $stable(code_q) && $stable(type_q));
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[FLG_DATA] && !(clr_we_i && clr_mask_i[FLG_DATA]) |=> flags_q[FLG_DATA]);
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned TYPE_W = 5,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              dbe_i,
  input  logic              par_i,
  input  logic              ext_mc_i,
  input  logic              wdog_i,
  input  logic              ao_to_i,
  input  logic [CODE_W-1:0] xfer_code_i,
  input  logic [TYPE_W-1:0] xfer_type_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mcp_o,
  output logic              tea_o
);
  localparam int unsigned TYPE_LSB = CODE_W;

  logic                 dis_q, mcp_q, tea_q;
  logic                 sbe_en, ue_en, data_mc, mc_now, sat;
  logic                 wr_status, wr_count;
  logic [CNT_W-1:0]     cnt;
  logic [NUM_FLAGS-1:0] flags, flag_set;
  logic [CODE_W-1:0]    cap_code;
  logic [TYPE_W-1:0]    cap_type;

  assign wr_status = reg_we_i && (reg_addr_i == ADDR_W'(REG_STATUS));
  assign wr_count  = reg_we_i && (reg_addr_i == ADDR_W'(REG_COUNT));

  assign sbe_en  = sbe_i && !dis_q;
  assign ue_en   = (dbe_i || par_i) && !dis_q;
  assign data_mc = ue_en || (sbe_en && sat);
  assign mc_now  = data_mc || ext_mc_i || wdog_i || ao_to_i;

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DATA] = data_mc;
    flag_set[FLG_EXT]  = ext_mc_i;
    flag_set[FLG_WDOG] = wdog_i;
    flag_set[FLG_AO]   = ao_to_i;
  end

  bec_ecc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sbe_i      (sbe_i),
    .dis_i      (dis_q),
    .load_i     (wr_count),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .cnt_o      (cnt),
    .sat_o      (sat)
  );

  bec_capture #(.CODE_W(CODE_W), .TYPE_W(TYPE_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mc_i       (mc_now),
    .set_i      (flag_set),
    .clr_we_i   (wr_status),
    .clr_mask_i (reg_wdata_i[FLAG_LSB +: NUM_FLAGS]),
    .code_i     (xfer_code_i),
    .type_i     (xfer_type_i),
    .flags_o    (flags),
    .code_o     (cap_code),
    .type_o     (cap_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= 1'b0;
      mcp_q <= 1'b0;
      tea_q <= 1'b0;
    end else begin
      if (wr_status) dis_q <= reg_wdata_i[DIS_BIT];
      mcp_q <= mc_now;
      tea_q <= ue_en;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(REG_STATUS)) begin
      reg_rdata_o[CODE_W-1:0]              = cap_code;
      reg_rdata_o[TYPE_LSB +: TYPE_W]      = cap_type;
      reg_rdata_o[DIS_BIT]                 = dis_q;
      reg_rdata_o[FLAG_LSB +: NUM_FLAGS]   = flags;
    end else if (reg_addr_i == ADDR_W'(REG_COUNT)) begin
      reg_rdata_o[CNT_W-1:0] = cnt;
    end
  end

  assign mcp_o = mcp_q;
  assign tea_o = tea_q;

  assert_no_esc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_i && !sat && !dbe_i && !par_i && !ext_mc_i && !wdog_i && !ao_to_i |=> !mcp_o && !tea_o);
  assert_esc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_i && !dis_q && sat |=> mcp_o);
  assert_tea_mcp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tea_o |-> mcp_o);
  assert_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_mc_i || wdog_i || ao_to_i |=> mcp_o);
endmodule

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe = 0, dbe = 0, par = 0, ext = 0, wd = 0, ao = 0;
  logic [2:0]  code = '0;
  logic [4:0]  typ = '0;
  logic        we = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mcp, tea;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  bus_err_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sbe_i(sbe), .dbe_i(dbe), .par_i(par),
    .ext_mc_i(ext), .wdog_i(wd), .ao_to_i(ao), .xfer_code_i(code),
    .xfer_type_i(typ), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mcp_o(mcp), .tea_o(tea)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  // bits: {ao, wd, ext, par, dbe, sbe}
  task automatic pulse(input logic [5:0] ev, input logic [2:0] c, input logic [4:0] t);
    {ao, wd, ext, par, dbe, sbe} = ev; code = c; typ = t;
    @(negedge clk);
    {ao, wd, ext, par, dbe, sbe} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_cnt;
    repeat (2) @(negedge clk);
    // R10 reset state
    rd(0, v); chk("R10 status reset", v, 0);
    rd(1, v); chk("R10 count reset", v, 0);
    chk("R10 mcp reset", mcp, 0);
    chk("R10 tea reset", tea, 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R2 full sweep from 0 through saturation
    exp_cnt = 0;
    for (int i = 0; i < 260; i++) begin
      logic exp_mc;
      exp_mc = (exp_cnt == 255);
      pulse(6'b000001, 3'(i), 5'(i));
      chk("R2 sweep mcp", mcp, 32'(exp_mc));
      chk("R2 sweep tea", tea, 0);
      if (exp_cnt < 255) exp_cnt++;
      rd(1, v); chk("R1 sweep count", v, exp_cnt);
    end
    rd(0, v); chk("R6 data flag from saturated sbe", v[12:9], 4'b0001);
    wr(0, 32'h1E00);
    rd(0, v); chk("R8 flags cleared", v[12:9], 0);

    // R3 preload near the top
    wr(1, 32'd250);
    rd(1, v); chk("R3 loaded value", v, 250);
    exp_cnt = 250;
    for (int i = 0; i < 7; i++) begin
      logic exp_mc;
      exp_mc = (exp_cnt == 255);
      pulse(6'b000001, 0, 0);
      chk("R3 preload mcp", mcp, 32'(exp_mc));
      if (exp_cnt < 255) exp_cnt++;
      rd(1, v); chk("R3 preload count", v, exp_cnt);
    end
    wr(0, 32'h1E00);

    // R9 write collides with sbe
    wr(1, 32'd20);
    sbe = 1; we = 1; addr = 1; wdata = 32'd7;
    @(negedge clk);
    sbe = 0; we = 0; wdata = '0;
    rd(1, v); chk("R9 write wins", v, 7);

    // R4 data errors disabled
    wr(0, 32'h100);
    rd(0, v); chk("R4 disable bit reads back", v, 32'h100);
    wr(1, 32'd255);
    for (int k = 0; k < 3; k++) begin
      pulse(6'(1 << k), 3'd4, 5'd9);
      chk("R4 disabled mcp", mcp, 0);
      chk("R4 disabled tea", tea, 0);
      rd(1, v); chk("R4 disabled count", v, 255);
      rd(0, v); chk("R4 disabled flags", v, 32'h100);
    end
    wr(0, 32'h0);

    // R5 double-bit and parity, R6 data flag, R8 capture
    wr(1, 32'd3);
    pulse(6'b000010, 3'd5, 5'h13);
    chk("R5 dbe mcp", mcp, 1);
    chk("R5 dbe tea", tea, 1);
    rd(1, v); chk("R5 dbe count", v, 3);
    rd(0, v); chk("R6 R8 dbe capture", v, 32'h200 | (32'h13 << 3) | 5);
    pulse(6'b000100, 3'd2, 5'd7);
    chk("R5 par mcp", mcp, 1);
    chk("R5 par tea", tea, 1);
    rd(1, v); chk("R5 par count", v, 3);
    rd(0, v); chk("R8 fields frozen", v, 32'h200 | (32'h13 << 3) | 5);
    wr(0, 32'h1E00);
    rd(0, v); chk("R8 fields kept after clear", v, (32'h13 << 3) | 5);

    // R7 other causes
    pulse(6'b001000, 3'd1, 5'd2);
    chk("R7 ext mcp", mcp, 1); chk("R7 ext tea", tea, 0);
    rd(0, v); chk("R7 ext flag", v, 32'h400 | (2 << 3) | 1);
    wr(0, 32'h1E00);
    pulse(6'b010000, 3'd6, 5'd31);
    chk("R7 wdog mcp", mcp, 1); chk("R7 wdog tea", tea, 0);
    rd(0, v); chk("R7 wdog flag", v, 32'h800 | (31 << 3) | 6);
    wr(0, 32'h1E00);
    pulse(6'b100000, 3'd0, 5'd0);
    chk("R7 ao mcp", mcp, 1); chk("R7 ao tea", tea, 0);
    rd(0, v); chk("R7 ao flag", v, 32'h1000);
    wr(0, 32'h1E00);

    // R8 selective clear
    pulse(6'b001000, 3'd3, 5'd10);
    pulse(6'b010000, 3'd7, 5'd1);
    rd(0, v); chk("R8 two flags first capture", v, 32'hC00 | (10 << 3) | 3);
    wr(0, 32'h400);
    rd(0, v); chk("R8 clear one flag", v, 32'h800 | (10 << 3) | 3);
    pulse(6'b001000, 3'd1, 5'd1);
    rd(0, v); chk("R8 still frozen", v, 32'hC00 | (10 << 3) | 3);
    wr(0, 32'h1E00);
    pulse(6'b001000, 3'd1, 5'd1);
    rd(0, v); chk("R8 capture after clear", v, 32'h400 | (1 << 3) | 1);
    wr(0, 32'h1E00);
    @(negedge clk);
    chk("R7 mcp drops", mcp, 0);

    // R10 reserved bits and unmapped address
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R10 reserved and fields ignore writes", v, 32'h100 | (1 << 3) | 1);
    wr(1, 32'hFFFF_FF00);
    rd(1, v); chk("R10 count reserved", v, 0);
    rd(2, v); chk("R10 unmapped", v, 0);
    rd(3, v); chk("R10 unmapped 3", v, 0);
    wr(0, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule